// File: doc/BRIEF.md
# Capture/Reload 16-bit Timer

This block is a 16-bit up-counter. It advances on one of two sources: a one-cycle tick from an on-chip timebase, or falling edges on an external count pin. A shared 16-bit holding register serves both as the reload value and as the capture target. On overflow from 0xFFFF the counter loads the holding register instead of wrapping to zero. A falling edge on an external trigger pin can force a reload or copy the live count into the holding register. Two sticky flags record overflow and trigger events, and software must clear both. The flags drive one interrupt request.

The control bits select one of three operating modes. The mode is decoded as an enumerated state: `MODE_RELOAD`, `MODE_CAPTURE` or `MODE_BAUD`. The control register changes the mode when either serial clock-select bit or the capture select bit is written:
- `MODE_BAUD` takes priority whenever either clock-select bit is set.
- Otherwise the capture select bit picks `MODE_CAPTURE` or `MODE_RELOAD`.

In `MODE_BAUD` the timer produces overflow pulses that a serial port can use as its transmit or receive bit clock. Each direction chooses between this timer's overflow and a peer timer's overflow.

Top module: `cr_timer16`

## Requirements
- R1: After reset the control register, counter and holding register read 0, and `irq` and `ovf_pulse` are 0.
- R2: With the run bit (control bit 0) at 0, the count holds and trigger edges do nothing. With it at 1, the count rises by one for each cycle that `tick_en` is high, when the count source bit is 0.
- R3: With the count source bit (control bit 1) at 1, the count advances once for each falling edge of `cnt_pin`, and `tick_en` has no effect. The pin passes through a two-flop synchronizer, so the count changes on the third rising clock edge after the pin falls.
- R4: An increment from 0xFFFF loads the holding register value into the count, not 0x0000. In the following cycle `ovf_pulse` is high for one cycle, and the overflow flag (control bit 6) is set.
- R5: In `MODE_RELOAD` with the trigger enable bit (control bit 3) at 1, a falling edge on `trig_pin` loads the holding register into the count and sets the trigger flag (control bit 7).
- R6: In `MODE_CAPTURE` (control bit 2 = 1) with trigger enable at 1, a `trig_pin` falling edge copies the count into the holding register. The count is not changed, and the trigger flag is set.
- R7: With trigger enable at 0, `trig_pin` edges change neither the count, the holding register nor the trigger flag.
- R8: When the transmit select (bit 4) or receive select (bit 5) is 1, the block is in `MODE_BAUD`. In this mode:
  - overflow reloads even if bit 2 is 1;
  - trigger edges are ignored;
  - the overflow flag is not set.
- R9: Hardware never clears a flag, so a set flag stays set until software clears it. When a software write to the control register and a hardware flag set fall in the same cycle, the flag ends up set.
- R10: `irq` is high exactly when `irq_en` is 1 and at least one flag is set.
- R11: `tx_baud_tick` follows `ovf_pulse` when bit 4 is 1 and follows `peer_ovf` when bit 4 is 0. `rx_baud_tick` does the same under control of bit 5.
- R12: The register port uses `reg_addr` to select a register:
  - 0 selects control (bits 7:0, upper bits read 0);
  - 1 selects the count;
  - 2 selects the holding register;
  - 3 reads 0.
  
  Writes take effect on the next clock edge, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Internal timebase tick |
| cnt_pin | input | 1 | External count pin, asynchronous |
| trig_pin | input | 1 | External trigger pin, asynchronous |
| irq_en | input | 1 | Interrupt enable |
| peer_ovf | input | 1 | Overflow pulse of another timer |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| irq | output | 1 | Interrupt request |
| ovf_pulse | output | 1 | One-cycle overflow pulse |
| tx_baud_tick | output | 1 | Transmit baud clock |
| rx_baud_tick | output | 1 | Receive baud clock |

## Verification
The bench targets the overflow boundary. A design that wraps to zero would read 0x0000 instead of the holding value. A design that mis-times the overflow pulse would miss the pulse in the sample window.

It checks that `MODE_BAUD` wins over capture select. A design that still captures, or that sets the overflow flag, leaves a wrong holding value or a wrong control read.

It drives a flag-clearing write in the same cycle as an overflow. A design where the write wins loses the overflow flag.

It checks that trigger edges are ignored when trigger enable is 0. It also counts pin edges while the timebase ticks, which catches a design that mixes up the two count sources.

// File: rtl/crt_pkg.sv
package crt_pkg;
    localparam int CNT_W  = 16;
    localparam int SYNC_N = 2;

    typedef enum logic [1:0] {
        MODE_RELOAD  = 2'd0,
        MODE_CAPTURE = 2'd1,
        MODE_BAUD    = 2'd2
    } crt_mode_e;

    typedef enum logic [1:0] {
        RA_CTRL  = 2'd0,
        RA_COUNT = 2'd1,
        RA_HOLD  = 2'd2,
        RA_NONE  = 2'd3
    } crt_addr_e;
endpackage

// File: rtl/crt_edge_sync.sv
module crt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    localparam int SH_W = STAGES + 1;
    logic [SH_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[SH_W-2:0], pin};
    end

    assign fall = sh_q[SH_W-1] & ~sh_q[SH_W-2];
endmodule

// File: rtl/crt_core.sv
module crt_core
    import crt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         ext_src,
    input  logic         cap_sel,
    input  logic         trig_en,
    input  logic         baud,
    input  logic         tick_en,
    input  logic         cnt_fall,
    input  logic         trig_fall,
    input  logic         cnt_we,
    input  logic         hold_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count_q,
    output logic [W-1:0] hold_q,
    output logic         ovf_evt,
    output logic         trig_evt,
    output logic         ovf_pulse
);
    localparam logic [W-1:0] TOP = '1;

    crt_mode_e mode;
    logic inc, trig_hit, trig_rl, trig_cap;

    always_comb begin
        if (baud)         mode = MODE_BAUD;
        else if (cap_sel) mode = MODE_CAPTURE;
        else              mode = MODE_RELOAD;
    end

    always_comb begin
        inc      = run && (ext_src ? cnt_fall : tick_en);
        ovf_evt  = inc && (count_q == TOP);
        trig_hit = run && trig_en && trig_fall;
        trig_rl  = 1'b0;
        trig_cap = 1'b0;
        unique case (mode)
            MODE_RELOAD:  trig_rl  = trig_hit;
            MODE_CAPTURE: trig_cap = trig_hit;
            MODE_BAUD:    ;
            default:      ;
        endcase
        trig_evt = trig_rl | trig_cap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q   <= '0;
            hold_q    <= '0;
            ovf_pulse <= 1'b0;
        end else begin
            ovf_pulse <= ovf_evt;
            if (cnt_we)                  count_q <= wdata;
            else if (ovf_evt || trig_rl) count_q <= hold_q;
            else if (inc)                count_q <= count_q + 1'b1;
            if (trig_cap)     hold_q <= count_q;
            else if (hold_we) hold_q <= wdata;
        end
    end

    a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_we) |=> $stable(count_q));
    a_r4_overflow_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !cnt_we) |=> (count_q == $past(hold_q)));
    a_r6_capture_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (run && trig_en && trig_fall && !baud && cap_sel) |=> (hold_q == $past(count_q)));
    a_r8_baud_ignores_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        baud |-> !trig_evt);
endmodule

// File: rtl/crt_ctrl.sv
module crt_ctrl #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_we,
    input  logic [7:0]   wdata,
    input  logic         ovf_evt,
    input  logic         trig_evt,
    input  logic         irq_en,
    output logic         run,
    output logic         ext_src,
    output logic         cap_sel,
    output logic         trig_en,
    output logic         tx_sel,
    output logic         rx_sel,
    output logic         baud,
    output logic [W-1:0] ctrl_rd,
    output logic         irq
);
    logic [5:0] bits_q;
    logic       ovf_flag_q, trig_flag_q;

    assign {rx_sel, tx_sel, trig_en, cap_sel, ext_src, run} = bits_q;
    assign baud = tx_sel | rx_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q      <= '0;
            ovf_flag_q  <= 1'b0;
            trig_flag_q <= 1'b0;
        end else begin
            if (ctrl_we) bits_q <= wdata[5:0];
            if (ovf_evt && !baud) ovf_flag_q <= 1'b1;
            else if (ctrl_we)     ovf_flag_q <= wdata[6];
            if (trig_evt)         trig_flag_q <= 1'b1;
            else if (ctrl_we)     trig_flag_q <= wdata[7];
        end
    end

    always_comb begin
        ctrl_rd      = '0;
        ctrl_rd[7:0] = {trig_flag_q, ovf_flag_q, bits_q};
    end

    assign irq = irq_en && (ovf_flag_q || trig_flag_q);

    a_r8_no_flag_in_baud: assert property (@(posedge clk) disable iff (!rst_n)
        (baud && !ovf_flag_q && !ctrl_we) |=> !ovf_flag_q);
    a_r9_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !baud) |=> ovf_flag_q);
    a_r7_no_trig_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_en && !trig_flag_q && !ctrl_we) |=> !trig_flag_q);
endmodule

// File: rtl/cr_timer16.sv
module cr_timer16
    import crt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    input  logic              irq_en,
    input  logic              peer_ovf,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              ovf_pulse,
    output logic              tx_baud_tick,
    output logic              rx_baud_tick
);
    localparam int NPIN = 2;

    logic [NPIN-1:0] pins, falls;
    logic run, ext_src, cap_sel, trig_en, tx_sel, rx_sel, baud;
    logic ovf_evt, trig_evt;
    logic [CNT_W-1:0] count_q, hold_q, ctrl_rd;

    assign pins = {trig_pin, cnt_pin};

    for (genvar i = 0; i < NPIN; i++) begin : g_sync
        crt_edge_sync #(.STAGES(SYNC_N)) u_sync (
            .clk(clk), .rst_n(rst_n), .pin(pins[i]), .fall(falls[i])
        );
    end

    crt_ctrl #(.W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(reg_wr && (reg_addr == RA_CTRL)),
        .wdata(reg_wdata[7:0]),
        .ovf_evt(ovf_evt), .trig_evt(trig_evt), .irq_en(irq_en),
        .run(run), .ext_src(ext_src), .cap_sel(cap_sel), .trig_en(trig_en),
        .tx_sel(tx_sel), .rx_sel(rx_sel), .baud(baud),
        .ctrl_rd(ctrl_rd), .irq(irq)
    );

    crt_core #(.W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .run(run), .ext_src(ext_src), .cap_sel(cap_sel), .trig_en(trig_en),
        .baud(baud), .tick_en(tick_en),
        .cnt_fall(falls[0]), .trig_fall(falls[1]),
        .cnt_we(reg_wr && (reg_addr == RA_COUNT)),
        .hold_we(reg_wr && (reg_addr == RA_HOLD)),
        .wdata(reg_wdata),
        .count_q(count_q), .hold_q(hold_q),
        .ovf_evt(ovf_evt), .trig_evt(trig_evt), .ovf_pulse(ovf_pulse)
    );

    always_comb begin
        unique case (reg_addr)
            RA_CTRL:  reg_rdata = ctrl_rd;
            RA_COUNT: reg_rdata = count_q;
            RA_HOLD:  reg_rdata = hold_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign tx_baud_tick = tx_sel ? ovf_pulse : peer_ovf;
    assign rx_baud_tick = rx_sel ? ovf_pulse : peer_ovf;
endmodule

// File: tb/tb_cr_timer16.sv
module tb_cr_timer16;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0, cnt_pin = 1'b1, trig_pin = 1'b1, irq_en = 1'b0, peer_ovf = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic irq, ovf_pulse, tx_baud_tick, rx_baud_tick;

    int compared = 0, mismatched = 0;
    bit done = 1'b0;
    string       exp_tag[$];
    logic [15:0] exp_val[$];

    always #4 clk = ~clk;

    cr_timer16 dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_pin(cnt_pin),
        .trig_pin(trig_pin), .irq_en(irq_en), .peer_ovf(peer_ovf),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .ovf_pulse(ovf_pulse),
        .tx_baud_tick(tx_baud_tick), .rx_baud_tick(rx_baud_tick)
    );

    task automatic push_exp(string tag, logic [15:0] v);
        exp_tag.push_back(tag);
        exp_val.push_back(v);
    endtask

    task automatic monitor(logic [15:0] got);
        string t;
        logic [15:0] e;
        t = exp_tag.pop_front();
        e = exp_val.pop_front();
        compared++;
        if (got !== e) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", t, got, e);
        end
    endtask

    task automatic chk_reg(string tag, logic [1:0] a, logic [15:0] e);
        push_exp(tag, e);
        reg_addr = a;
        #1;
        monitor(reg_rdata);
    endtask

    task automatic chk_sig(string tag, logic got, logic e);
        push_exp(tag, {15'd0, e});
        monitor({15'd0, got});
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic cnt_edge();
        @(negedge clk); cnt_pin = 1'b0;
        repeat (3) @(negedge clk);
        cnt_pin = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic trig_edge();
        @(negedge clk); trig_pin = 1'b0;
        repeat (3) @(negedge clk);
        trig_pin = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_reg("R1 ctrl", 2'd0, 16'h0000);
        chk_reg("R1 count", 2'd1, 16'h0000);
        chk_reg("R1 hold", 2'd2, 16'h0000);
        chk_sig("R1 irq", irq, 1'b0);
        chk_sig("R1 ovf_pulse", ovf_pulse, 1'b0);
        chk_reg("R12 unused addr", 2'd3, 16'h0000);

        // R2 timebase counting and hold
        wr(2'd1, 16'h0005);
        wr(2'd0, 16'h0001);
        ticks(3);
        chk_reg("R2 count after 3 ticks", 2'd1, 16'h0008);
        wr(2'd0, 16'h0000);
        ticks(2);
        chk_reg("R2 hold while stopped", 2'd1, 16'h0008);

        // R3 external pin counting
        wr(2'd0, 16'h0003);
        ticks(2);
        chk_reg("R3 ticks ignored", 2'd1, 16'h0008);
        cnt_edge();
        cnt_edge();
        chk_reg("R3 two pin edges", 2'd1, 16'h000A);

        // R4 overflow reload
        wr(2'd0, 16'h0001);
        wr(2'd2, 16'h1234);
        wr(2'd1, 16'hFFFE);
        ticks(1);
        @(negedge clk); tick_en = 1'b1;
        @(negedge clk); tick_en = 1'b0;
        chk_sig("R4 ovf_pulse", ovf_pulse, 1'b1);
        chk_reg("R4 count reloaded", 2'd1, 16'h1234);
        chk_reg("R4 ovf flag", 2'd0, 16'h0041);
        @(negedge clk);
        chk_sig("R4 pulse one cycle", ovf_pulse, 1'b0);
        chk_sig("R10 irq masked", irq, 1'b0);
        irq_en = 1'b1;
        #1;
        chk_sig("R10 irq asserted", irq, 1'b1);
        wr(2'd0, 16'h0001);
        chk_reg("R9 sw clear", 2'd0, 16'h0001);
        chk_sig("R10 irq after clear", irq, 1'b0);

        // R5 trigger reload
        wr(2'd0, 16'h0009);
        wr(2'd1, 16'h0100);
        trig_edge();
        chk_reg("R5 trigger reload", 2'd1, 16'h1234);
        chk_reg("R5 trigger flag", 2'd0, 16'h0089);
        chk_sig("R10 irq trig flag", irq, 1'b1);

        // R7 trigger disabled
        wr(2'd0, 16'h0001);
        wr(2'd1, 16'h0100);
        trig_edge();
        chk_reg("R7 count untouched", 2'd1, 16'h0100);
        chk_reg("R7 no flag", 2'd0, 16'h0001);

        // R6 capture
        wr(2'd0, 16'h000D);
        wr(2'd1, 16'h0777);
        trig_edge();
        chk_reg("R6 captured", 2'd2, 16'h0777);
        chk_reg("R6 count kept", 2'd1, 16'h0777);
        chk_reg("R6 flag", 2'd0, 16'h008D);

        // R8 baud mode overrides capture
        wr(2'd0, 16'h001D);
        wr(2'd1, 16'h0200);
        trig_edge();
        chk_reg("R8 trigger ignored count", 2'd1, 16'h0200);
        chk_reg("R8 trigger ignored hold", 2'd2, 16'h0777);
        wr(2'd2, 16'h4000);
        wr(2'd1, 16'hFFFF);
        @(negedge clk); tick_en = 1'b1;
        @(negedge clk); tick_en = 1'b0;
        chk_sig("R11 tx follows overflow", tx_baud_tick, 1'b1);
        chk_sig("R11 rx follows peer", rx_baud_tick, 1'b0);
        chk_reg("R8 reload in baud", 2'd1, 16'h4000);
        @(negedge clk);
        chk_reg("R8 no ovf flag", 2'd0, 16'h001D);
        peer_ovf = 1'b1;
        #1;
        chk_sig("R11 rx peer high", rx_baud_tick, 1'b1);
        chk_sig("R11 tx own low", tx_baud_tick, 1'b0);
        peer_ovf = 1'b0;

        // R9 hardware set wins over same-cycle clear
        wr(2'd0, 16'h0001);
        wr(2'd2, 16'h0000);
        wr(2'd1, 16'hFFFF);
        @(negedge clk);
        reg_addr = 2'd0; reg_wdata = 16'h0001; reg_wr = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tick_en = 1'b0;
        chk_reg("R9 hw set wins", 2'd0, 16'h0041);
        repeat (5) @(negedge clk);
        chk_reg("R9 flag sticky", 2'd0, 16'h0041);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule